// File: doc/BRIEF.md
# Bypassed Two-Read Register File

This block holds thirty-two 32-bit general registers for a pipelined core. It has one write port and two independent read ports whose results are combinational. In its bypassing forms a value presented on the write port in a cycle is already returned by any read of that register in the same cycle. A decode stage can therefore pick up a result that a later stage is committing in that very cycle, without waiting one more cycle.

The parameter `MODE` chooses how this works. `RF_PLAIN` (0) has no bypass. `RF_FWD` (1) compares the write port with each read index and forwards. `RF_BUF` (2) first lands each write in a one-entry pending buffer, which is drained into the array on the following clock. Both reads search that buffer as well as the incoming write. `RF_FWD` and `RF_BUF` look the same at the ports. They differ only in when the array itself is written. Register 0 is hard-wired to zero. Hazard tracking and stalls belong to the surrounding pipeline.

Top module: `bypass_regfile`

## Requirements
- R1: With `rst` high at a rising edge, every register is cleared, including a write still pending in the buffer. Afterwards each read returns 0 until that register is written.
- R2: A read of index 0 returns 0 on either port at all times. This also holds in the cycle a write to index 0 is presented, and in every later cycle.
- R3: The two read ports are independent. Each returns the value of the index on its own address input, whatever the other port reads.
- R4: A write (`wr_en`=1) to a non-zero index stores `wr_data` at the rising edge. Reads return that value from the next cycle on, until the register is written again or reset.
- R5: In `MODE` 1 or 2, a read whose index equals `wr_addr` while `wr_en`=1 and the index is non-zero returns `wr_data` in that same cycle.
- R6: Forwarding needs `wr_en`=1 and all 5 index bits equal. With `wr_en`=0, or with indices that differ in any single bit, the read returns the stored value.
- R7: In `MODE` 0, a read of the register being written returns its old contents in that cycle. The new value appears on the following cycle.
- R8: In `MODE` 2, writes in back-to-back cycles lose nothing. This holds whether they go to the same register (the last one wins) or to different registers (all are kept).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |
| rd_a_addr | input | 5 | Index for read port A |
| rd_a_data | output | 32 | Value read on port A |
| rd_b_addr | input | 5 | Index for read port B |
| rd_b_data | output | 32 | Value read on port B |

## Verification
One stimulus stream drives three copies of the block at once, one in each mode. The plain copy is compared against the value stored before the edge, and the two bypassing copies against the newly written value. Any same-cycle hazard therefore separates the plain form from the forwarding forms. The patterns are:
- a full sweep of writes with the two ports reading unrelated registers, which separates per-port indexing faults;
- reads that collide with the write, with the enable low, with one address bit flipped, and with index 0, which together isolate the forwarding compare;
- back-to-back writes to one register and to a row of registers, which expose a buffer that drops or reorders its drain;
- a reset that lands while a write is still pending, which shows whether reset clears the buffer.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    RF_PLAIN = 2'd0,
    RF_FWD   = 2'd1,
    RF_BUF   = 2'd2
  } rf_mode_e;
endpackage

// File: rtl/rf_storage.sv
// Register array: one synchronous write port, NRD asynchronous reads.
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int NRD    = 2,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [NRD-1:0][ADDR_W-1:0]    rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end
endmodule

// File: rtl/rf_wbuf.sv
// One-entry pending-write buffer, drained into the array one cycle later.
module rf_wbuf #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend_vld  <= in_en && (in_addr != '0);
      pend_addr <= in_addr;
      pend_data <= in_data;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
// One read port: incoming write, then pending buffer, then array.
module rf_read_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter bit FWD_EN = 1'b1,
  parameter bit BUF_EN = 1'b0
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] rd_data
);
  logic hit_wr, hit_pend;

  assign hit_wr   = FWD_EN && wr_en && (wr_addr == rd_addr);
  assign hit_pend = BUF_EN && pend_vld && (pend_addr == rd_addr);

  always_comb begin
    if (rd_addr == '0)  rd_data = '0;
    else if (hit_wr)    rd_data = wr_data;
    else if (hit_pend)  rd_data = pend_data;
    else                rd_data = arr_data;
  end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile
  import rf_pkg::*;
#(
  parameter int       DATA_W = 32,
  parameter int       NREG   = 32,
  parameter rf_mode_e MODE   = RF_BUF,
  localparam int      ADDR_W = $clog2(NREG),
  localparam int      NRD    = 2,
  localparam bit      FWD_ON = (MODE != RF_PLAIN),
  localparam bit      BUF_ON = (MODE == RF_BUF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  logic                       arr_we;
  logic [ADDR_W-1:0]          arr_wa;
  logic [DATA_W-1:0]          arr_wd;
  logic                       pend_vld;
  logic [ADDR_W-1:0]          pend_addr;
  logic [DATA_W-1:0]          pend_data;
  logic [NRD-1:0][ADDR_W-1:0] ra;
  logic [NRD-1:0][DATA_W-1:0] arr_rd;
  logic [NRD-1:0][DATA_W-1:0] rd;

  assign ra[0]     = rd_a_addr;
  assign ra[1]     = rd_b_addr;
  assign rd_a_data = rd[0];
  assign rd_b_data = rd[1];

  if (BUF_ON) begin : g_buf
    rf_wbuf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wbuf (
      .clk      (clk),
      .rst      (rst),
      .in_en    (wr_en),
      .in_addr  (wr_addr),
      .in_data  (wr_data),
      .pend_vld (pend_vld),
      .pend_addr(pend_addr),
      .pend_data(pend_data)
    );
    assign arr_we = pend_vld;
    assign arr_wa = pend_addr;
    assign arr_wd = pend_data;
  end else begin : g_direct
    assign pend_vld  = 1'b0;
    assign pend_addr = '0;
    assign pend_data = '0;
    assign arr_we    = wr_en;
    assign arr_wa    = wr_addr;
    assign arr_wd    = wr_data;
  end

  rf_storage #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (arr_we),
    .wr_addr(arr_wa),
    .wr_data(arr_wd),
    .rd_addr(ra),
    .rd_data(arr_rd)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_read_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FWD_EN(FWD_ON), .BUF_EN(BUF_ON)
    ) u_rp (
      .rd_addr  (ra[p]),
      .arr_data (arr_rd[p]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pend_vld (pend_vld),
      .pend_addr(pend_addr),
      .pend_data(pend_data),
      .rd_data  (rd[p])
    );
  end
endmodule

// File: rtl/bypass_regfile_chk.sv
module bypass_regfile_chk
  import rf_pkg::*;
#(
  parameter int       DATA_W = 32,
  parameter int       ADDR_W = 5,
  parameter rf_mode_e MODE   = RF_BUF
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data
);
  localparam bit BYP = (MODE != RF_PLAIN);
  logic seen = 1'b0;
  logic prev_rst = 1'b0;
  logic fwd_a, fwd_b;

  always_ff @(posedge clk) begin
    seen     <= 1'b1;
    prev_rst <= rst;
  end

  assign fwd_a = BYP && wr_en && (wr_addr == rd_a_addr);
  assign fwd_b = BYP && wr_en && (wr_addr == rd_b_addr);

  // R2
  p_zero_idx_r2: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_addr == '0) |-> (rd_a_data == '0)) and
    ((rd_b_addr == '0) |-> (rd_b_data == '0)));

  // R1
  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (seen && prev_rst) |-> ((rd_a_data == '0 || fwd_a) && (rd_b_data == '0 || fwd_b)));

  // R5
  p_same_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (fwd_a && rd_a_addr != '0) |-> (rd_a_data == wr_data));

  // R4
  p_persist_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && wr_en && wr_addr != '0) |=>
      (rd_a_addr != $past(wr_addr) || fwd_a || rd_a_data == $past(wr_data)));

  // R7 / R6: with no write last cycle and a steady index, the value holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(!rst) && $past(!wr_en) && $stable(rd_b_addr) && !fwd_b)
      |-> $stable(rd_b_data));
endmodule

bind bypass_regfile bypass_regfile_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE(MODE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
);

// File: tb/sim_bypass_regfile.sv
module sim_bypass_regfile;
  import rf_pkg::*;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  ra = '0, rb = '0;
  logic [31:0] buf_a, buf_b, pln_a, pln_b, fwd_a, fwd_b;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] model [32];

  always #(CLK_PER/2) clk = ~clk;

  bypass_regfile #(.MODE(RF_BUF)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(ra), .rd_a_data(buf_a), .rd_b_addr(rb), .rd_b_data(buf_b));
  bypass_regfile #(.MODE(RF_PLAIN)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(ra), .rd_a_data(pln_a), .rd_b_addr(rb), .rd_b_data(pln_b));
  bypass_regfile #(.MODE(RF_FWD)) u2 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(ra), .rd_a_data(fwd_a), .rd_b_addr(rb), .rd_b_data(fwd_b));

  task automatic chk(input string tag, input string who,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, who, act, exp);
    end
  endtask

  // One clock: drive at falling edge, check before the rising edge, update model.
  task automatic step(input string tag, input logic we, input int wa,
                      input logic [31:0] wd, input int aa, input int ab);
    logic [31:0] pa, pb, ba, bb;
    @(negedge clk);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd; ra = 5'(aa); rb = 5'(ab);
    #1;
    pa = (aa == 0) ? 32'd0 : model[aa];
    pb = (ab == 0) ? 32'd0 : model[ab];
    ba = (aa != 0 && we && wa == aa) ? wd : pa;
    bb = (ab != 0 && we && wa == ab) ? wd : pb;
    chk(tag, "buf port A", buf_a, ba);
    chk(tag, "buf port B", buf_b, bb);
    chk(tag, "fwd port A", fwd_a, ba);
    chk(tag, "fwd port B", fwd_b, bb);
    chk(tag, "plain port A", pln_a, pa);
    chk(tag, "plain port B", pln_b, pb);
    if (we && wa != 0) model[wa] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    do_reset();
    // R1: reset state on every index
    for (int i = 0; i < 32; i++) step("R1", 1'b0, 0, 32'h0, i, 31 - i);
    // R4 / R3: fill all registers, ports read unrelated indices
    for (int i = 1; i < 32; i++)
      step("R4", 1'b1, i, 32'hA500_0000 ^ (32'(i) * 32'h0101_0103), i - 1, 32 - i);
    for (int i = 0; i < 32; i++) step("R3", 1'b0, 0, 32'h0, i, (i * 7) % 32);
    // R5 / R7: same-cycle collision on both ports
    step("R5", 1'b1, 5, 32'hCAFE_0005, 5, 5);
    step("R7", 1'b1, 6, 32'hBEEF_0006, 6, 3);
    step("R4", 1'b0, 0, 32'h0, 6, 5);
    // R6: enable low with matching index; single-bit index differences
    step("R6", 1'b0, 8, 32'h1111_1111, 8, 8);
    step("R6", 1'b1, 21, 32'h2222_2222, 5, 20);
    step("R6", 1'b1, 12, 32'h3333_3333, 13, 4);
    step("R6", 1'b0, 0, 32'h0, 21, 12);
    // R2: write to index 0 while reading it, then read again
    step("R2", 1'b1, 0, 32'hDEAD_BEEF, 0, 0);
    step("R2", 1'b0, 0, 32'h0, 0, 0);
    step("R2", 1'b1, 0, 32'h1234_5678, 0, 1);
    // R8: back-to-back writes, same register then a row of registers
    step("R8", 1'b1, 9, 32'h9000_0001, 9, 9);
    step("R8", 1'b1, 9, 32'h9000_0002, 9, 0);
    step("R8", 1'b1, 9, 32'h9000_0003, 9, 9);
    step("R8", 1'b0, 0, 32'h0, 9, 9);
    for (int i = 10; i < 16; i++) step("R8", 1'b1, i, 32'h7700_0000 + 32'(i), i - 1, i);
    for (int i = 9; i < 16; i++) step("R8", 1'b0, 0, 32'h0, i, i);
    // R1: reset while a write is still pending in the buffer
    step("R1", 1'b1, 7, 32'h0707_0707, 7, 0);
    do_reset();
    step("R1", 1'b0, 0, 32'h0, 7, 9);
    step("R1", 1'b0, 0, 32'h0, 5, 31);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule